// File: doc/BRIEF.md
# Cascadable FIFO Slice Ring

A FIFO built from identical storage slices joined in a ring. Each slice owns a small local memory with its own write and read pointers. It also tracks two independent permission tokens, one for writing and one for reading. The write and read strobes go to every slice at once. Only the slice that holds the matching token acts on a strobe, and only if its local flag allows it.

When a slice accepts a write into its last physical location, it raises a one-cycle write-pass pulse toward the next slice in the ring. It raises a separate read-pass pulse when it reads its last location. The receiving slice takes the token at the same clock edge, so the next strobe lands in that slice's location zero with no lost cycle. A slice marked as first-load holds both tokens when reset ends. No address is shared between slices.

The top wrapper cascades a parameterised number of slices, three by default, and marks slice zero as first-load. It closes the ring from the last slice back to the first. It forms composite full as the AND of the per-slice full flags and composite empty as the AND of the per-slice empty flags. It returns read data from whichever slice performed the read. Seen from its ports, the cascade is one FIFO of depth SLICES×DEPTH.

Top module: `cas_fifo`

## Requirements
- R1: While reset is low and in the first cycle after it, `empty` is 1, `full` is 0 and `rvalid` is 0.
- R2: Words come out of `rdata` in the order they were accepted. This holds across every slice boundary, for up to SLICES×DEPTH stored words.
- R3: After SLICES×DEPTH accepted writes with no read, `full` is 1. A write strobed while `full` is 1 is not stored: the words later read back contain only the accepted ones.
- R4: Once every stored word has been read, `empty` is 1. A read strobed while `empty` is 1 produces no `rvalid` pulse and removes nothing.
- R5: A read is accepted when `rd_en` is 1 and `empty` is 0 at a rising edge. The word appears on `rdata` with `rvalid` = 1 in the following cycle. `rvalid` is 0 in every other cycle.
- R6: At all times exactly one slice holds the write token and exactly one holds the read token. Reaching a slice's last location passes the token to the next slice at that same edge. Back-to-back strobes therefore continue without a gap.
- R7: In a cycle with both strobes high, the write is accepted if `full` is 0 and the read is accepted if `empty` is 0. Both take effect in the same cycle, and the occupancy then stays the same.
- R8: After the last slice's last location, the tokens return to slice zero, location zero. The ring can wrap any number of times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sent to all slices |
| wdata | input | WIDTH | Word to write |
| rd_en | input | 1 | Read strobe, sent to all slices |
| rdata | output | WIDTH | Word read, valid when rvalid is 1 |
| rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| empty | output | 1 | Composite empty: all slices empty |
| full | output | 1 | Composite full: all slices full |

## Verification
The hardest situation to reach is a token wrapping from the last slice back to slice zero while slice zero still holds unread words. This state exists only with a partly full ring whose two tokens sit in different slices, and only after the write token has travelled all the way round. A random phase first biases traffic toward writing and then toward reading. This walks both tokens round the ring several times at many different offsets. A phase of simultaneous read and write at fixed occupancy drags the gap between the two tokens across every slice boundary. Each cycle's outputs are compared against a queue model.

// File: rtl/cas_fifo_pkg.sv
package cas_fifo_pkg;

  // Pointer width needed to address a slice of the given depth.
  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

  // Count width that can hold the value depth itself.
  function automatic int unsigned cnt_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  // Next physical location, wrapping after the last one.
  function automatic int unsigned wrap_step(input int unsigned cur, input int unsigned depth);
    return (cur == depth - 1) ? 0 : cur + 1;
  endfunction

  // Ring neighbour that feeds slice k.
  function automatic int unsigned ring_prev(input int unsigned k, input int unsigned slices);
    return (k + slices - 1) % slices;
  endfunction

endpackage

// File: rtl/cas_lane.sv
// One permission lane: a token plus the local pointer it drives.
module cas_lane #(
  parameter int DEPTH = 8,
  parameter int AW    = cas_fifo_pkg::ptr_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_own,
  input  logic          req,
  input  logic          ok,
  input  logic          pass_in,
  output logic          fire,
  output logic          pass_out,
  output logic          own,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign fire     = req & own & ok;
  assign pass_out = fire & (ptr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own <= init_own;
      ptr <= '0;
    end else begin
      own <= pass_in | (own & ~pass_out);
      if (fire) ptr <= AW'(cas_fifo_pkg::wrap_step(int'(ptr), DEPTH));
    end
  end

  // R6: handing the token on leaves this lane without it
  a_r6_pass_releases: assert property (@(posedge clk) disable iff (!rst_n)
    pass_out && !pass_in |=> !own);
  // R6: an incoming pass always lands
  a_r6_pass_lands: assert property (@(posedge clk) disable iff (!rst_n)
    pass_in |=> own);
  // R8: a pass leaves the pointer at location zero
  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pass_out |=> (ptr == '0));
endmodule

// File: rtl/cas_store.sv
// Local word storage with a registered read port.
module cas_store #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8,
  parameter int AW    = cas_fifo_pkg::ptr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cas_slice.sv
// One cascadable slice: two token lanes, storage and local occupancy.
module cas_slice #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_load,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_en,
  input  logic             xin_wr,
  input  logic             xin_rd,
  output logic             xout_wr,
  output logic             xout_rd,
  output logic             wtok,
  output logic             rtok,
  output logic [WIDTH-1:0] rdata,
  output logic             rvalid,
  output logic             empty,
  output logic             full
);
  localparam int AW = cas_fifo_pkg::ptr_bits(DEPTH);
  localparam int CW = cas_fifo_pkg::cnt_bits(DEPTH);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] cnt;
  logic [AW-1:0] wp, rp;
  logic          wr_fire, rd_fire;

  assign empty = (cnt == '0);
  assign full  = (cnt == FULL_CNT);

  cas_lane #(.DEPTH(DEPTH), .AW(AW)) u_wlane (
    .clk(clk), .rst_n(rst_n), .init_own(first_load), .req(wr_en), .ok(~full),
    .pass_in(xin_wr), .fire(wr_fire), .pass_out(xout_wr), .own(wtok), .ptr(wp));

  cas_lane #(.DEPTH(DEPTH), .AW(AW)) u_rlane (
    .clk(clk), .rst_n(rst_n), .init_own(first_load), .req(rd_en), .ok(~empty),
    .pass_in(xin_rd), .fire(rd_fire), .pass_out(xout_rd), .own(rtok), .ptr(rp));

  cas_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(wr_fire), .waddr(wp), .wdata(wdata),
    .re(rd_fire), .raddr(rp), .rdata(rdata));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      rvalid <= 1'b0;
    end else begin
      cnt    <= cnt + CW'(wr_fire) - CW'(rd_fire);
      rvalid <= rd_fire;
    end
  end

  // R3: a full slice stays full until it gives up a word
  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rd_fire |=> full);
  // R4: an empty slice stays empty until it takes a word
  a_r4_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !wr_fire |=> empty);
  // R5: local read data is flagged exactly one cycle after the local read
  a_r5_slice_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rvalid);
endmodule

// File: rtl/cas_fifo.sv
// Ring of cascaded slices forming one deep FIFO.
module cas_fifo #(
  parameter int WIDTH  = 9,
  parameter int DEPTH  = 8,
  parameter int SLICES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rdata,
  output logic             rvalid,
  output logic             empty,
  output logic             full
);
  logic [SLICES-1:0] xo_wr, xo_rd, xi_wr, xi_rd;
  logic [SLICES-1:0] wtok_v, rtok_v, rv_v, em_v, fu_v;
  logic [WIDTH-1:0]  sl_rd [SLICES];

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    localparam int PREV = cas_fifo_pkg::ring_prev(k, SLICES);
    assign xi_wr[k] = xo_wr[PREV];
    assign xi_rd[k] = xo_rd[PREV];

    cas_slice #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_slice (
      .clk(clk), .rst_n(rst_n), .first_load(k == 0),
      .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
      .xin_wr(xi_wr[k]), .xin_rd(xi_rd[k]),
      .xout_wr(xo_wr[k]), .xout_rd(xo_rd[k]),
      .wtok(wtok_v[k]), .rtok(rtok_v[k]),
      .rdata(sl_rd[k]), .rvalid(rv_v[k]),
      .empty(em_v[k]), .full(fu_v[k]));
  end

  assign empty  = &em_v;
  assign full   = &fu_v;
  assign rvalid = |rv_v;

  always_comb begin
    rdata = '0;
    for (int k = 0; k < SLICES; k++)
      if (rv_v[k]) rdata = rdata | sl_rd[k];
  end

  // R6: one write token and one read token in the ring
  a_r6_wtok_single: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wtok_v) == 1);
  a_r6_rtok_single: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rtok_v) == 1);
  // R6: at most one pass pulse of each kind per cycle
  a_r6_pass_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xo_wr) && $onehot0(xo_rd));
  // R5: a data beat is always caused by an accepted read
  a_r5_rvalid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rd_en && !empty));
  // R2: only one slice drives read data at a time
  a_r2_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rv_v));
  // R3: composite flags never both set
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: tb/cas_fifo_bench.sv
`timescale 1ns/1ps
module cas_fifo_bench;
  localparam int W   = 9;
  localparam int N   = 8;
  localparam int S   = 3;
  localparam int CAP = N * S;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         rvalid, empty, full;

  int    q[$];
  int    tests = 0;
  int    fails = 0;
  bit    exp_rv = 1'b0;
  int    exp_rd = 0;
  string tag = "R1";
  int    seq = 0;

  cas_fifo #(.WIDTH(W), .DEPTH(N), .SLICES(S)) u_cas_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata), .rvalid(rvalid), .empty(empty), .full(full));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Check outputs of the previous cycle, then drive this cycle and update the model.
  task automatic step(input bit w, input bit r);
    int sz0;
    chk("R5", "rvalid", int'(rvalid), int'(exp_rv));
    if (exp_rv) chk(tag, "rdata", int'(rdata), exp_rd);
    chk("R4", "empty", int'(empty), int'(q.size() == 0));
    chk("R3", "full", int'(full), int'(q.size() == CAP));
    sz0    = q.size();
    wr_en  = w;
    rd_en  = r;
    wdata  = W'((seq * 37 + 5) % 512);
    exp_rv = 1'b0;
    if (r && sz0 > 0) begin
      exp_rv = 1'b1;
      exp_rd = q.pop_front();
    end
    if (w && sz0 < CAP) begin
      q.push_back(int'(wdata));
      seq++;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "full", int'(full), 0);
    chk("R1", "rvalid", int'(rvalid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "empty after release", int'(empty), 1);
    chk("R1", "rvalid after release", int'(rvalid), 0);

    // R6 / R3: back-to-back writes across slice boundaries, then extra writes while full
    tag = "R6";
    for (int i = 0; i < CAP + 4; i++) step(1'b1, 1'b0);
    // R2: back-to-back drain in order; R4: extra reads while empty
    tag = "R2";
    for (int i = 0; i < CAP + 4; i++) step(1'b0, 1'b1);

    // R7: steady simultaneous read and write at partial occupancy
    tag = "R7";
    for (int i = 0; i < 11; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 3 * CAP; i++) step(1'b1, 1'b1);
    // R7: both strobes while full (read only) and while empty (write only)
    for (int i = 0; i < CAP; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    for (int i = 0; i < CAP + 2; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);

    // R8: biased random traffic wraps both tokens round the ring many times
    tag = "R8";
    for (int i = 0; i < 1200; i++) begin
      int pw;
      pw = ((i / 90) % 2 == 0) ? 75 : 30;
      step($urandom_range(0, 99) < pw, $urandom_range(0, 99) < (100 - pw));
    end
    for (int i = 0; i < CAP + 2; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule